// File: doc/BRIEF.md
# Host Bridge Address Router

This block sits between the processor's memory request path and the targets behind the host bridge. It takes one request at a time with a physical address and a flag that says whether the processor is in system management mode. It picks exactly one destination for the request: system DRAM, the downstream chipset link, the configuration-space translator, or an abort response. The result appears, registered, one cycle after the request is accepted.

Firmware sets up the window registers over a simple write port while the router is idle. These registers are the top of low DRAM, the reclaim base and limit, the SMM segment base, and the configuration window base and bus count. Reclaimed DRAM lies above 4 GB and stands in for the DRAM hidden behind the PCI hole. For such an address the router returns a translated DRAM address. For a configuration hit it returns the bus, device, function and register offset decoded from the address.

Top module: `hb_addr_router`

## Requirements
- R1: After reset no response is pending and `reqReady` is high. The top of low DRAM is 0x8000_0000, the reclaim window is off (base above limit), the SMM segment is empty (its base equals the top of low DRAM), and the configuration window is off (bus count 0).
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both high. Its result is valid on `rspValid` from the next edge. `reqReady` is high whenever `rspValid` is low or `rspReady` is high.
- R3: Target codes are 0 = DRAM, 1 = downstream link, 2 = configuration, 3 = abort. When windows overlap, the first match in this order wins: configuration window, SMM segment, reclaim window, PCI hole, DRAM. An address that matches none of them goes to the link.
- R4: The configuration window starts at its base and spans (bus count × 1 MB). Bus counts above 256 are stored as 256, and a count of 0 turns the window off. For an address in the window, take off = address − base. Then `cfgBus` = off[27:20], `cfgDev` = off[19:15], `cfgFunc` = off[14:12] and `cfgReg` = off[11:0]. All four fields are zero for any other target.
- R5: The SMM segment covers [SMM base, top of low DRAM). With `smmMode` high it goes to DRAM. With `smmMode` low it gets target 3 (abort) and never DRAM.
- R6: When the reclaim base is not above the reclaim limit, the reclaim window covers [base, limit + 0xF_FFFF]. A hit there goes to DRAM, and `rspAddr` = address − reclaim base + top of low DRAM.
- R7: Addresses in [top of low DRAM, 4 GB) go to the link. Addresses below the top of low DRAM, and addresses in [4 GB, reclaim base), go to DRAM. For every target except a reclaim hit, `rspAddr` is the request address unchanged.
- R8: While `rspValid` is high and `rspReady` is low, the response and all its fields stay unchanged and `reqReady` is low.
- R9: A window write happens on an edge where `cfgWrEn` is high and both `rspValid` and `reqValid` are low. A write at any other time is dropped. Select codes: 0 top of low DRAM, 1 reclaim base, 2 reclaim limit, 3 SMM base, 4 configuration base, 5 bus count. Codes 6 and 7 are ignored.
- R10: Bits 19:0 of the top of low DRAM, reclaim base, reclaim limit, SMM base and configuration base are stored as zero, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Router can take a request |
| reqAddr | input | ADDR_W | Physical address of the request |
| smmMode | input | 1 | Request issued in system management mode |
| rspValid | output | 1 | Routing result present |
| rspReady | input | 1 | Consumer takes the result |
| rspTarget | output | 2 | Target code |
| rspAddr | output | ADDR_W | Forwarded (possibly translated) address |
| cfgBus | output | 8 | Decoded bus number |
| cfgDev | output | 5 | Decoded device number |
| cfgFunc | output | 3 | Decoded function number |
| cfgReg | output | 12 | Decoded register offset |
| cfgWrEn | input | 1 | Window register write strobe |
| cfgWrSel | input | 3 | Window register select |
| cfgWrData | input | ADDR_W | Window register write value |

## Verification
The hardest case to reach is a window write that arrives while a result is stalled behind a low `rspReady` and a second request is already waiting. The write must be dropped, the stalled result must hold, and the waiting request must then be routed with the old windows. The bench forces this case on purpose. It holds `rspReady` low, queues a new request, and pulses a write that would move the top of low DRAM. It then releases the stall and routes an address whose target would change if the write had landed. A second window setup places the configuration window on top of the SMM segment to show the priority order. Boundary-biased random addresses then cover each window edge and are checked against a behavioural model.

// File: rtl/hb_route_pkg.sv
package hb_route_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM  = 2'd0,
    TGT_LINK  = 2'd1,
    TGT_CFG   = 2'd2,
    TGT_ABORT = 2'd3
  } route_tgt_e;

  typedef enum logic [2:0] {
    WIN_TOLUD      = 3'd0,
    WIN_RECL_BASE  = 3'd1,
    WIN_RECL_LIMIT = 3'd2,
    WIN_SMM_BASE   = 3'd3,
    WIN_CFG_BASE   = 3'd4,
    WIN_CFG_BUSES  = 3'd5
  } win_sel_e;

  typedef struct packed {
    logic capture;
    logic winWrite;
  } route_strb_t;
endpackage

// File: rtl/hb_route_ctrl.sv
module hb_route_ctrl
  import hb_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        cfgWrEn,
  output logic        reqReady,
  output logic        rspValid,
  output route_strb_t strb
);
  always_comb begin
    reqReady      = !rspValid || rspReady;
    strb.capture  = reqValid && reqReady;
    strb.winWrite = cfgWrEn && !rspValid && !reqValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rspValid <= 1'b0;
    else if (strb.capture) rspValid <= 1'b1;
    else if (rspReady)     rspValid <= 1'b0;
  end

  // Response hold under back-pressure (R8)
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !rspReady |=> rspValid);

  // A result only appears after a request was offered (R2)
  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rspValid) |-> $past(reqValid));
endmodule

// File: rtl/hb_route_dp.sv
module hb_route_dp
  import hb_route_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  route_strb_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              smmMode,
  input  logic [2:0]        cfgWrSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic [1:0]        rspTarget,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFunc,
  output logic [11:0]       cfgReg
);
  localparam int MB_SHIFT  = 20;
  localparam int BUSCNT_W  = 9;
  localparam int MAX_BUSES = 256;
  localparam logic [ADDR_W-1:0] GRAN_MASK  = ADDR_W'((64'd1 << MB_SHIFT) - 64'd1);
  localparam logic [ADDR_W-1:0] FOUR_G     = ADDR_W'(64'h1_0000_0000);
  localparam logic [ADDR_W-1:0] TOLUD_RST  = ADDR_W'(64'h8000_0000);

  logic [ADDR_W-1:0]   winTolud, winReclBase, winReclLimit, winSmmBase, winCfgBase;
  logic [BUSCNT_W-1:0] winCfgBuses;
  logic [ADDR_W-1:0]   wrAligned;

  assign wrAligned = cfgWrData & ~GRAN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winTolud     <= TOLUD_RST;
      winReclBase  <= ~GRAN_MASK;
      winReclLimit <= '0;
      winSmmBase   <= TOLUD_RST;
      winCfgBase   <= '0;
      winCfgBuses  <= '0;
    end else if (strb.winWrite) begin
      case (cfgWrSel)
        WIN_TOLUD:      winTolud     <= wrAligned;
        WIN_RECL_BASE:  winReclBase  <= wrAligned;
        WIN_RECL_LIMIT: winReclLimit <= wrAligned;
        WIN_SMM_BASE:   winSmmBase   <= wrAligned;
        WIN_CFG_BASE:   winCfgBase   <= wrAligned;
        WIN_CFG_BUSES:  winCfgBuses  <= (cfgWrData > ADDR_W'(MAX_BUSES)) ?
                                        BUSCNT_W'(MAX_BUSES) : cfgWrData[BUSCNT_W-1:0];
        default: ;
      endcase
    end
  end

  // Range decode
  logic [ADDR_W:0]   cfgEnd;
  logic [ADDR_W-1:0] cfgOff, reclAddr;
  logic cfgHit, smmHit, reclOn, reclHit, holeHit, dramHit;
  route_tgt_e nxtTarget;
  logic [ADDR_W-1:0] nxtAddr;

  always_comb begin
    cfgEnd   = {1'b0, winCfgBase} + ((ADDR_W+1)'(winCfgBuses) << MB_SHIFT);
    cfgOff   = reqAddr - winCfgBase;
    reclAddr = reqAddr - winReclBase + winTolud;
    cfgHit   = (winCfgBuses != '0) && (reqAddr >= winCfgBase) && ({1'b0, reqAddr} < cfgEnd);
    smmHit   = (reqAddr >= winSmmBase) && (reqAddr < winTolud);
    reclOn   = winReclBase <= winReclLimit;
    reclHit  = reclOn && (reqAddr >= winReclBase) && (reqAddr <= (winReclLimit | GRAN_MASK));
    holeHit  = (reqAddr >= winTolud) && (reqAddr < FOUR_G);
    dramHit  = (reqAddr < winTolud) || ((reqAddr >= FOUR_G) && (reqAddr < winReclBase));

    nxtAddr = reqAddr;
    if (cfgHit)       nxtTarget = TGT_CFG;
    else if (smmHit)  nxtTarget = smmMode ? TGT_DRAM : TGT_ABORT;
    else if (reclHit) begin
      nxtTarget = TGT_DRAM;
      nxtAddr   = reclAddr;
    end
    else if (holeHit) nxtTarget = TGT_LINK;
    else if (dramHit) nxtTarget = TGT_DRAM;
    else              nxtTarget = TGT_LINK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspTarget <= TGT_DRAM;
      rspAddr   <= '0;
      cfgBus    <= '0;
      cfgDev    <= '0;
      cfgFunc   <= '0;
      cfgReg    <= '0;
    end else if (strb.capture) begin
      rspTarget <= nxtTarget;
      rspAddr   <= nxtAddr;
      cfgBus    <= cfgHit ? cfgOff[27:20] : '0;
      cfgDev    <= cfgHit ? cfgOff[19:15] : '0;
      cfgFunc   <= cfgHit ? cfgOff[14:12] : '0;
      cfgReg    <= cfgHit ? cfgOff[11:0]  : '0;
    end
  end

  // SMM-mode requests are never aborted (R5)
  p_smm_no_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture && smmMode |=> rspTarget != TGT_ABORT);

  // Result holds between captures (R8)
  p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(rspTarget) && $stable(rspAddr));

  // Windows do not move on the edge a request is taken (R9)
  p_win_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> $stable(winTolud) && $stable(winReclBase) && $stable(winCfgBase));

  // Decoded configuration fields are zero for other targets (R4)
  p_cfg_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rspTarget != TGT_CFG |-> (cfgBus == 8'd0 && cfgDev == 5'd0 && cfgFunc == 3'd0 && cfgReg == 12'd0));
endmodule

// File: rtl/hb_addr_router.sv
module hb_addr_router
  import hb_route_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              smmMode,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [1:0]        rspTarget,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFunc,
  output logic [11:0]       cfgReg,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgWrSel,
  input  logic [ADDR_W-1:0] cfgWrData
);
  route_strb_t strb;

  hb_route_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .rspReady(rspReady),
    .cfgWrEn(cfgWrEn), .reqReady(reqReady), .rspValid(rspValid), .strb(strb)
  );

  hb_route_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqAddr(reqAddr), .smmMode(smmMode),
    .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData), .rspTarget(rspTarget),
    .rspAddr(rspAddr), .cfgBus(cfgBus), .cfgDev(cfgDev), .cfgFunc(cfgFunc),
    .cfgReg(cfgReg)
  );
endmodule

// File: tb/sim_hb_addr_router.sv
`timescale 1ns/100ps
module sim_hb_addr_router;
  localparam int AW = 36;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reqValid = 0, rspReady = 1, smmMode = 0, cfgWrEn = 0;
  logic [AW-1:0] reqAddr = '0, cfgWrData = '0;
  logic [2:0] cfgWrSel = '0;
  logic reqReady, rspValid;
  logic [1:0] rspTarget;
  logic [AW-1:0] rspAddr;
  logic [7:0] cfgBus; logic [4:0] cfgDev; logic [2:0] cfgFunc; logic [11:0] cfgReg;

  always #2.5 clk = ~clk;

  hb_addr_router #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .smmMode(smmMode), .rspValid(rspValid), .rspReady(rspReady),
    .rspTarget(rspTarget), .rspAddr(rspAddr), .cfgBus(cfgBus), .cfgDev(cfgDev),
    .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // Behavioural model state
  logic [63:0] mTolud = 64'h8000_0000, mReclBase = 64'hF_FFF0_0000, mReclLimit = 0;
  logic [63:0] mSmmBase = 64'h8000_0000, mCfgBase = 0, mCfgBuses = 0;
  localparam logic [63:0] LOWM = 64'hF_FFFF;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] a, input bit smm, output int t,
                       output logic [63:0] oa, output logic [63:0] f);
    logic [63:0] off;
    off = a - mCfgBase; oa = a; f = 0;
    if (mCfgBuses != 0 && a >= mCfgBase && a < mCfgBase + mCfgBuses * 64'h10_0000) begin
      t = 2; f = {off[27:20], off[19:15], off[14:12], off[11:0]};
    end else if (a >= mSmmBase && a < mTolud) t = smm ? 0 : 3;
    else if (mReclBase <= mReclLimit && a >= mReclBase && a <= (mReclLimit | LOWM)) begin
      t = 0; oa = a - mReclBase + mTolud;
    end else if (a >= mTolud && a < 64'h1_0000_0000) t = 1;
    else if (a < mTolud || (a >= 64'h1_0000_0000 && a < mReclBase)) t = 0;
    else t = 1;
  endtask

  // Caller is at a falling edge with rspReady high.
  task automatic sendReq(string tag, logic [63:0] a, bit smm);
    int t; logic [63:0] oa, f;
    model(a, smm, t, oa, f);
    reqValid = 1; reqAddr = a[AW-1:0]; smmMode = smm;
    while (!reqReady) @(negedge clk);
    @(posedge clk); @(negedge clk);
    reqValid = 0;
    chk({tag, " valid"}, 64'(rspValid), 64'd1);
    chk({tag, " target"}, 64'(rspTarget), 64'(t));
    chk({tag, " addr"}, 64'(rspAddr), oa);
    chk({tag, " fields"}, {36'd0, cfgBus, cfgDev, cfgFunc, cfgReg}, f);
  endtask

  task automatic wrWin(logic [2:0] sel, logic [63:0] d);
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1; cfgWrSel = sel; cfgWrData = d[AW-1:0];
    @(posedge clk); @(negedge clk);
    cfgWrEn = 0;
    case (sel)
      3'd0: mTolud = d & ~LOWM;
      3'd1: mReclBase = d & ~LOWM;
      3'd2: mReclLimit = d & ~LOWM;
      3'd3: mSmmBase = d & ~LOWM;
      3'd4: mCfgBase = d & ~LOWM;
      3'd5: mCfgBuses = (d > 256) ? 256 : d;
      default: ;
    endcase
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rspValid", 64'(rspValid), 0);
    chk("R1 reqReady", 64'(reqReady), 1);
    sendReq("R1 hole default", 64'h9000_0000, 0);
    sendReq("R1 low dram", 64'h7FFF_FFFF, 0);
    sendReq("R1 upper dram", 64'h1_2000_0000, 0);
    sendReq("R1 no smm seg", 64'h7FF0_0000, 0);

    // R10 masking, R9 selects
    wrWin(3'd0, 64'hC001_2345);
    wrWin(3'd3, 64'hBF80_0ABC);
    wrWin(3'd1, 64'h2_0000_0000);
    wrWin(3'd2, 64'h2_3FF0_0000);
    wrWin(3'd4, 64'hC000_0000);
    wrWin(3'd5, 64'd64);
    wrWin(3'd6, 64'h1234_5678);  // ignored select (R9)
    sendReq("R10 tolud masked", 64'hC000_0000, 0);

    // R4 configuration decode
    sendReq("R4 cfg example", 64'hC001_1040, 0);
    sendReq("R4 cfg last", 64'hC3FF_FFFC, 0);
    sendReq("R7 hole past cfg", 64'hC400_0000, 0);
    // R5 SMM
    sendReq("R5 smm blocked", 64'hBF80_0000, 0);
    sendReq("R5 smm allowed", 64'hBFFF_FFF0, 1);
    sendReq("R7 below smm", 64'hBF7F_FFFF, 0);
    // R6 reclaim
    sendReq("R6 recl start", 64'h2_0000_0000, 0);
    sendReq("R6 recl end", 64'h2_3FFF_FFFF, 0);
    sendReq("R7 above recl", 64'h2_4000_0000, 0);
    sendReq("R7 upper dram", 64'h1_8000_0000, 0);
    sendReq("R7 hole top", 64'hFFFF_FFF0, 1);

    // R8 / R9 stall with a blocked window write
    @(posedge clk); @(negedge clk);
    rspReady = 0; reqValid = 1; reqAddr = 36'h2_0000_0040; smmMode = 0;
    @(posedge clk); @(negedge clk);
    reqAddr = 36'h0_0000_0010;
    cfgWrEn = 1; cfgWrSel = 3'd0; cfgWrData = 36'h4000_0000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      cfgWrEn = 0;
      chk("R8 hold valid", 64'(rspValid), 1);
      chk("R8 hold ready", 64'(reqReady), 0);
      chk("R8 hold target", 64'(rspTarget), 0);
      chk("R8 hold addr", 64'(rspAddr), 64'hC000_0040);
    end
    rspReady = 1;
    @(posedge clk); @(negedge clk);
    reqValid = 0;
    chk("R2 queued valid", 64'(rspValid), 1);
    chk("R2 queued addr", 64'(rspAddr), 64'h10);
    sendReq("R9 write dropped", 64'h5000_0000, 0);

    // R3 priority: configuration window over the SMM segment
    wrWin(3'd4, 64'hBFC0_0000);
    wrWin(3'd5, 64'd999);
    sendReq("R3 cfg over smm", 64'hBFC0_2000, 0);
    sendReq("R3 smm under cfg", 64'hBFBF_FFFF, 0);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] b, a;
      case ($urandom % 7)
        0: b = mTolud;
        1: b = mSmmBase;
        2: b = mReclBase;
        3: b = (mReclLimit | LOWM) + 1;
        4: b = mCfgBase + mCfgBuses * 64'h10_0000;
        5: b = 64'h1_0000_0000;
        default: b = {28'd0, 4'($urandom), 32'($urandom)};
      endcase
      a = (b + 64'($urandom % 64) - 64'd32) & 64'hF_FFFF_FFFF;
      sendReq("R3 random", a, bit'($urandom % 2));
    end
    summary();
  end
endmodule